// File: doc/BRIEF.md
# Data-Side Translation Check and Fault Status Unit

This unit sits beside a data translation buffer on the load/store path. For each access it takes the virtual address, the access direction, the current privilege mode, the privileged-code and alternate-mode controls, the instruction's opcode and destination register, and the lookup result already produced by the translation array. The array itself lives outside this block. The unit runs the address-validity, direct-mapped (superpage) and page-permission checks in a fixed priority. One clock later it answers with either a physical address or a fault kind.

When an access faults and the record is free, the unit captures three words: the faulting virtual address, a packed status word, and a formatted page-table-entry address. The record then locks so that later faults cannot overwrite it. The lock holds until software reads the virtual-address word, which it signals with a read strobe. Six event counters track hits, misses and violations separately for loads and stores.

Top module: `dtf_unit`

## Requirements
- R1: A request sampled at a clock edge produces `rsp_valid_o` high after that same edge, together with `rsp_kind_o` and `rsp_paddr_o`. A cycle with no request produces `rsp_valid_o` low. `rsp_paddr_o` is zero whenever the kind is not none. Kind codes: 0 none, 1 access violation, 2 translation fault, 3 page-table-access miss, 4 data miss.
- R2: Mode codes are 0 kernel, 1 executive, 2 supervisor and 3 user. The effective mode selects bit `mode` of the read-enable or write-enable vector. The effective mode is normally `cur_mode_i`. When `pal_mode_i` is set, the effective mode is kernel, unless `alt_req_i` is also set, in which case it is `alt_mode_i`.
- R3: The validity check comes first. An address is invalid when bits [VA_W-1:VA_SIG-1] are neither all zeros nor all ones. An invalid address gives kind 2 with the flags bad-VA and access-violation, plus the write flag for a store.
- R4: The superpage check comes second. It applies when `spage_en_i` is set and VA bits [VA_SIG-1:VA_SIG-2] equal binary 10. In kernel mode the access bypasses the lookup, and the physical address is VA[PA_W-1:0]. In any other mode the result is kind 1 with the access-violation flag, plus the write flag for a store. When `spage_en_i` is clear, the same address goes to the lookup.
- R5: On a lookup miss the result is kind 3 if `req_pt_i` is set and kind 4 otherwise. The flags are the miss flag, plus the write flag for a store.
- R6: A store whose write-enable bit is clear gives kind 2 with the flags write and access-violation, plus fault-on-write when the fault-on-write bit is set. Otherwise, a set fault-on-write bit gives kind 2 with the flags write and fault-on-write. Otherwise the store hits, with physical address {pfn, VA[PAGE_W-1:0]}.
- R7: A load whose read-enable bit is clear gives kind 1 with the access-violation flag, plus fault-on-read when the fault-on-read bit is set. Otherwise, a set fault-on-read bit gives kind 2 with the fault-on-read flag alone. Otherwise the load hits.
- R8: The status word places the opcode in bits 16:11, the destination register in bits 10:6 and the flags in bits 5:0. Within the flags, bit 0 is write, 1 access-violation, 2 fault-on-read, 3 fault-on-write, 4 miss and 5 bad-VA.
- R9: On capture, the VA word holds the full virtual address. The formatted word holds `pt_base_i` OR (VA[VA_SIG-1:PAGE_W] shifted left by 3).
- R10: A fault is captured only while the record is unlocked, and capture sets the lock. A `va_rd_i` strobe clears the lock; a fault arriving in that cycle is not captured. A capture in the same cycle as a strobe, taken while unlocked, leaves the record locked.
- R11: Six counters track load hits, load misses, load violations, store hits, store misses and store violations. A violation is any fault other than a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Access present this cycle |
| req_va_i | input | VA_W | Virtual address |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_pt_i | input | 1 | Access is a page-table-entry fetch |
| req_opcode_i | input | 6 | Opcode of the instruction |
| req_reg_i | input | 5 | Destination register number |
| cur_mode_i | input | 2 | Current privilege mode |
| pal_mode_i | input | 1 | Executing privileged code |
| alt_req_i | input | 1 | Access requests the alternate mode |
| alt_mode_i | input | 2 | Alternate mode value |
| spage_en_i | input | 1 | Superpage mapping enabled |
| pt_base_i | input | VA_W | Page-table base for the formatted address |
| tlb_hit_i | input | 1 | Lookup found a matching entry |
| tlb_pfn_i | input | PA_W-PAGE_W | Frame number of the entry |
| tlb_rd_en_i | input | 4 | Read enable per mode |
| tlb_wr_en_i | input | 4 | Write enable per mode |
| tlb_for_i | input | 1 | Fault-on-read bit of the entry |
| tlb_fow_i | input | 1 | Fault-on-write bit of the entry |
| va_rd_i | input | 1 | Software read strobe of the VA word |
| rsp_valid_o | output | 1 | Response present |
| rsp_kind_o | output | 3 | Fault kind |
| rsp_paddr_o | output | PA_W | Physical address on success |
| fault_va_o | output | VA_W | Captured virtual address |
| fault_stat_o | output | 17 | Captured status word |
| fault_form_o | output | VA_W | Captured formatted address |
| fault_lock_o | output | 1 | Record locked |
| cnt_rd_hit_o | output | CNT_W | Load hits |
| cnt_rd_miss_o | output | CNT_W | Load misses |
| cnt_rd_viol_o | output | CNT_W | Load violations |
| cnt_wr_hit_o | output | CNT_W | Store hits |
| cnt_wr_miss_o | output | CNT_W | Store misses |
| cnt_wr_viol_o | output | CNT_W | Store violations |

## Verification
The hardest situation to reach is the interplay of the lock with later faults. A fault that arrives while the record is held must leave all three words untouched. A fault that coincides with the read strobe must not be captured either. The stimulus reaches this by deliberately raising a second fault of a different kind while locked, then pairing another fault with the strobe. The scoreboard's own lock model predicts which of these writes land. A further case is a privileged-code access that uses the alternate mode: it reaches a permission fault even though the current mode alone would pass.

// File: rtl/dtf_pkg.sv
package dtf_pkg;
   typedef enum logic [1:0] {
      MODE_KERN = 2'd0,
      MODE_EXEC = 2'd1,
      MODE_SUPV = 2'd2,
      MODE_USER = 2'd3
   } dtf_mode_e;

   typedef enum logic [2:0] {
      FK_NONE      = 3'd0,
      FK_ACCESS    = 3'd1,
      FK_TRANSLATE = 3'd2,
      FK_MISS_PT   = 3'd3,
      FK_MISS_DATA = 3'd4
   } dtf_kind_e;

   localparam int FLG_WR    = 0;
   localparam int FLG_ACV   = 1;
   localparam int FLG_FOR   = 2;
   localparam int FLG_FOW   = 3;
   localparam int FLG_MISS  = 4;
   localparam int FLG_BADVA = 5;
   localparam int FLAG_W    = 6;
   localparam int OPC_W     = 6;
   localparam int REG_W     = 5;
   localparam int STAT_W    = OPC_W + REG_W + FLAG_W;
   localparam int NUM_MODES = 4;
endpackage

// File: rtl/dtf_mode_sel.sv
module dtf_mode_sel
   import dtf_pkg::*;
(
   input  logic [1:0] cur_mode_i,
   input  logic       pal_mode_i,
   input  logic       alt_req_i,
   input  logic [1:0] alt_mode_i,
   output dtf_mode_e  eff_mode_o
);
   always_comb begin
      if (!pal_mode_i)     eff_mode_o = dtf_mode_e'(cur_mode_i);
      else if (alt_req_i)  eff_mode_o = dtf_mode_e'(alt_mode_i);
      else                 eff_mode_o = MODE_KERN;
   end
endmodule

// File: rtl/dtf_check.sv
module dtf_check
   import dtf_pkg::*;
#(
   parameter int VA_W   = 48,
   parameter int VA_SIG = 43,
   parameter int PA_W   = 40,
   parameter int PAGE_W = 13,
   localparam int PFN_W = PA_W - PAGE_W
)(
   input  logic [VA_W-1:0]      va_i,
   input  logic                 store_i,
   input  logic                 pt_i,
   input  dtf_mode_e            mode_i,
   input  logic                 spage_en_i,
   input  logic                 hit_i,
   input  logic [PFN_W-1:0]     pfn_i,
   input  logic [NUM_MODES-1:0] rd_en_i,
   input  logic [NUM_MODES-1:0] wr_en_i,
   input  logic                 for_i,
   input  logic                 fow_i,
   output dtf_kind_e            kind_o,
   output logic [FLAG_W-1:0]    flags_o,
   output logic [PA_W-1:0]      paddr_o
);
   localparam int UPPER_W = VA_W - VA_SIG + 1;

   logic [UPPER_W-1:0] upper;
   logic               va_ok;
   logic               in_spage;
   logic               perm_ok;
   logic               fo_bit;

   assign upper    = va_i[VA_W-1:VA_SIG-1];
   assign va_ok    = (&upper) | ~(|upper);
   assign in_spage = spage_en_i && (va_i[VA_SIG-1:VA_SIG-2] == 2'b10);
   assign perm_ok  = store_i ? wr_en_i[mode_i] : rd_en_i[mode_i];
   assign fo_bit   = store_i ? fow_i : for_i;

   always_comb begin
      kind_o  = FK_NONE;
      flags_o = '0;
      paddr_o = '0;
      flags_o[FLG_WR] = store_i;
      if (!va_ok) begin
         kind_o             = FK_TRANSLATE;
         flags_o[FLG_BADVA] = 1'b1;
         flags_o[FLG_ACV]   = 1'b1;
      end else if (in_spage) begin
         if (mode_i != MODE_KERN) begin
            kind_o           = FK_ACCESS;
            flags_o[FLG_ACV] = 1'b1;
         end else begin
            paddr_o = va_i[PA_W-1:0];
         end
      end else if (!hit_i) begin
         kind_o            = pt_i ? FK_MISS_PT : FK_MISS_DATA;
         flags_o[FLG_MISS] = 1'b1;
      end else if (!perm_ok) begin
         kind_o           = store_i ? FK_TRANSLATE : FK_ACCESS;
         flags_o[FLG_ACV] = 1'b1;
         flags_o[store_i ? FLG_FOW : FLG_FOR] = fo_bit;
      end else if (fo_bit) begin
         kind_o = FK_TRANSLATE;
         flags_o[store_i ? FLG_FOW : FLG_FOR] = 1'b1;
      end else begin
         paddr_o = {pfn_i, va_i[PAGE_W-1:0]};
      end
      if (kind_o != FK_NONE) paddr_o = '0;
      if (kind_o == FK_NONE) flags_o = '0;
   end
endmodule

// File: rtl/dtf_fault_regs.sv
module dtf_fault_regs
   import dtf_pkg::*;
#(
   parameter int VA_W = 48
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fault_i,
   input  logic [VA_W-1:0]   va_i,
   input  logic [STAT_W-1:0] stat_i,
   input  logic [VA_W-1:0]   form_i,
   input  logic              va_rd_i,
   output logic [VA_W-1:0]   va_o,
   output logic [STAT_W-1:0] stat_o,
   output logic [VA_W-1:0]   form_o,
   output logic              lock_o
);
   logic capture;
   assign capture = fault_i && !lock_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         va_o   <= '0;
         stat_o <= '0;
         form_o <= '0;
         lock_o <= 1'b0;
      end else begin
         if (capture) begin
            va_o   <= va_i;
            stat_o <= stat_i;
            form_o <= form_i;
            lock_o <= 1'b1;
         end else if (va_rd_i) begin
            lock_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dtf_counters.sv
module dtf_counters #(
   parameter int CNT_W = 16,
   localparam int NDIR = 2,
   localparam int NEVT = 3
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ev_valid_i,
   input  logic                        ev_store_i,
   input  logic                        ev_hit_i,
   input  logic                        ev_miss_i,
   output logic [NDIR*NEVT-1:0][CNT_W-1:0] cnt_o
);
   logic [NEVT-1:0] evt_sel;
   assign evt_sel = {!ev_hit_i && !ev_miss_i, ev_miss_i, ev_hit_i};

   for (genvar d = 0; d < NDIR; d++) begin : g_dir
      for (genvar e = 0; e < NEVT; e++) begin : g_evt
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (ev_valid_i && (ev_store_i == d[0]) && evt_sel[e])
               cnt_q <= cnt_q + 1'b1;
         end
         assign cnt_o[d*NEVT+e] = cnt_q;
      end
   end
endmodule

// File: rtl/dtf_unit.sv
module dtf_unit
   import dtf_pkg::*;
#(
   parameter int VA_W   = 48,
   parameter int VA_SIG = 43,
   parameter int PA_W   = 40,
   parameter int PAGE_W = 13,
   parameter int CNT_W  = 16,
   localparam int PFN_W = PA_W - PAGE_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic [VA_W-1:0]   req_va_i,
   input  logic              req_store_i,
   input  logic              req_pt_i,
   input  logic [5:0]        req_opcode_i,
   input  logic [4:0]        req_reg_i,
   input  logic [1:0]        cur_mode_i,
   input  logic              pal_mode_i,
   input  logic              alt_req_i,
   input  logic [1:0]        alt_mode_i,
   input  logic              spage_en_i,
   input  logic [VA_W-1:0]   pt_base_i,
   input  logic              tlb_hit_i,
   input  logic [PFN_W-1:0]  tlb_pfn_i,
   input  logic [3:0]        tlb_rd_en_i,
   input  logic [3:0]        tlb_wr_en_i,
   input  logic              tlb_for_i,
   input  logic              tlb_fow_i,
   input  logic              va_rd_i,
   output logic              rsp_valid_o,
   output logic [2:0]        rsp_kind_o,
   output logic [PA_W-1:0]   rsp_paddr_o,
   output logic [VA_W-1:0]   fault_va_o,
   output logic [16:0]       fault_stat_o,
   output logic [VA_W-1:0]   fault_form_o,
   output logic              fault_lock_o,
   output logic [CNT_W-1:0]  cnt_rd_hit_o,
   output logic [CNT_W-1:0]  cnt_rd_miss_o,
   output logic [CNT_W-1:0]  cnt_rd_viol_o,
   output logic [CNT_W-1:0]  cnt_wr_hit_o,
   output logic [CNT_W-1:0]  cnt_wr_miss_o,
   output logic [CNT_W-1:0]  cnt_wr_viol_o
);
   localparam int VPN_W = VA_SIG - PAGE_W;

   if (VA_SIG > VA_W || VA_SIG - 2 < PAGE_W) begin : g_bad_va
      $error("dtf_unit: VA_SIG must lie in [PAGE_W+2, VA_W]");
   end
   if (PA_W > VA_W || PA_W <= PAGE_W) begin : g_bad_pa
      $error("dtf_unit: PA_W must lie in (PAGE_W, VA_W]");
   end
   if (VPN_W + 3 > VA_W) begin : g_bad_vpn
      $error("dtf_unit: shifted page number does not fit the formatted word");
   end

   dtf_mode_e           eff_mode;
   dtf_kind_e           kind;
   logic [FLAG_W-1:0]   flags;
   logic [PA_W-1:0]     paddr;
   logic [STAT_W-1:0]   stat_word;
   logic [VA_W-1:0]     form_word;
   logic                is_fault;
   logic                is_miss;
   logic [5:0][CNT_W-1:0] cnts;

   dtf_mode_sel u_mode (
      .cur_mode_i (cur_mode_i),
      .pal_mode_i (pal_mode_i),
      .alt_req_i  (alt_req_i),
      .alt_mode_i (alt_mode_i),
      .eff_mode_o (eff_mode)
   );

   dtf_check #(
      .VA_W(VA_W), .VA_SIG(VA_SIG), .PA_W(PA_W), .PAGE_W(PAGE_W)
   ) u_check (
      .va_i       (req_va_i),
      .store_i    (req_store_i),
      .pt_i       (req_pt_i),
      .mode_i     (eff_mode),
      .spage_en_i (spage_en_i),
      .hit_i      (tlb_hit_i),
      .pfn_i      (tlb_pfn_i),
      .rd_en_i    (tlb_rd_en_i),
      .wr_en_i    (tlb_wr_en_i),
      .for_i      (tlb_for_i),
      .fow_i      (tlb_fow_i),
      .kind_o     (kind),
      .flags_o    (flags),
      .paddr_o    (paddr)
   );

   assign is_fault  = req_valid_i && (kind != FK_NONE);
   assign is_miss   = (kind == FK_MISS_PT) || (kind == FK_MISS_DATA);
   assign stat_word = {req_opcode_i, req_reg_i, flags};
   assign form_word = pt_base_i | (VA_W'(req_va_i[VA_SIG-1:PAGE_W]) << 3);

   dtf_fault_regs #(.VA_W(VA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .fault_i (is_fault),
      .va_i    (req_va_i),
      .stat_i  (stat_word),
      .form_i  (form_word),
      .va_rd_i (va_rd_i),
      .va_o    (fault_va_o),
      .stat_o  (fault_stat_o),
      .form_o  (fault_form_o),
      .lock_o  (fault_lock_o)
   );

   dtf_counters #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_valid_i (req_valid_i),
      .ev_store_i (req_store_i),
      .ev_hit_i   (kind == FK_NONE),
      .ev_miss_i  (is_miss),
      .cnt_o      (cnts)
   );

   assign cnt_rd_hit_o  = cnts[0];
   assign cnt_rd_miss_o = cnts[1];
   assign cnt_rd_viol_o = cnts[2];
   assign cnt_wr_hit_o  = cnts[3];
   assign cnt_wr_miss_o = cnts[4];
   assign cnt_wr_viol_o = cnts[5];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_o <= 1'b0;
         rsp_kind_o  <= FK_NONE;
         rsp_paddr_o <= '0;
      end else begin
         rsp_valid_o <= req_valid_i;
         rsp_kind_o  <= req_valid_i ? kind  : FK_NONE;
         rsp_paddr_o <= req_valid_i ? paddr : '0;
      end
   end
endmodule

// File: rtl/dtf_unit_chk.sv
module dtf_unit_chk #(
   parameter int VA_W = 48
)(
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid_i,
   input logic            va_rd_i,
   input logic            rsp_valid_o,
   input logic [VA_W-1:0] fault_va_o,
   input logic [16:0]     fault_stat_o,
   input logic [VA_W-1:0] fault_form_o,
   input logic            fault_lock_o
);
   assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i |=> rsp_valid_o);

   assert_no_rsp_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid_i |=> !rsp_valid_o);

   assert_lock_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_lock_o && !va_rd_i) |=> fault_lock_o);

   assert_lock_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_lock_o && va_rd_i) |=> !fault_lock_o);

   assert_record_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fault_lock_o |=> ($stable(fault_va_o) && $stable(fault_stat_o) && $stable(fault_form_o)));

   assert_capture_has_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_lock_o) |-> (fault_stat_o[5:0] != 6'd0));
endmodule

bind dtf_unit dtf_unit_chk #(.VA_W(VA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid_i  (req_valid_i),
   .va_rd_i      (va_rd_i),
   .rsp_valid_o  (rsp_valid_o),
   .fault_va_o   (fault_va_o),
   .fault_stat_o (fault_stat_o),
   .fault_form_o (fault_form_o),
   .fault_lock_o (fault_lock_o)
);

// File: tb/dtf_unit_tb.sv
`timescale 1ns/1ps
module dtf_unit_tb;
   localparam int VA_W = 48, VA_SIG = 43, PA_W = 40, PAGE_W = 13, CNT_W = 16;
   localparam int PFN_W = PA_W - PAGE_W;

   typedef struct {
      logic [VA_W-1:0] va; bit st; bit pt; bit pal; bit alt;
      logic [1:0] cm; logic [1:0] am; bit sp; bit hit;
      logic [PFN_W-1:0] pfn; logic [3:0] re; logic [3:0] we;
      bit fr; bit fw; logic [5:0] opc; logic [4:0] rg; bit vrd;
   } req_t;

   typedef struct {
      logic [2:0] kind; logic [PA_W-1:0] pa;
      logic [VA_W-1:0] fva; logic [16:0] fst; logic [VA_W-1:0] ffm;
      bit lk; string tag;
   } exp_t;

   logic clk = 0, rst_n = 0;
   always #2 clk = ~clk;

   logic req_valid_i = 0, req_store_i = 0, req_pt_i = 0, pal_mode_i = 0, alt_req_i = 0;
   logic spage_en_i = 0, tlb_hit_i = 0, tlb_for_i = 0, tlb_fow_i = 0, va_rd_i = 0;
   logic [VA_W-1:0] req_va_i = '0, pt_base_i = 48'h0000_4000_0000;
   logic [5:0] req_opcode_i = '0;
   logic [4:0] req_reg_i = '0;
   logic [1:0] cur_mode_i = '0, alt_mode_i = '0;
   logic [PFN_W-1:0] tlb_pfn_i = '0;
   logic [3:0] tlb_rd_en_i = '0, tlb_wr_en_i = '0;
   logic rsp_valid_o, fault_lock_o;
   logic [2:0] rsp_kind_o;
   logic [PA_W-1:0] rsp_paddr_o;
   logic [VA_W-1:0] fault_va_o, fault_form_o;
   logic [16:0] fault_stat_o;
   logic [CNT_W-1:0] c_rh, c_rm, c_rv, c_wh, c_wm, c_wv;

   dtf_unit #(.VA_W(VA_W), .VA_SIG(VA_SIG), .PA_W(PA_W), .PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_va_i(req_va_i),
      .req_store_i(req_store_i), .req_pt_i(req_pt_i), .req_opcode_i(req_opcode_i),
      .req_reg_i(req_reg_i), .cur_mode_i(cur_mode_i), .pal_mode_i(pal_mode_i),
      .alt_req_i(alt_req_i), .alt_mode_i(alt_mode_i), .spage_en_i(spage_en_i),
      .pt_base_i(pt_base_i), .tlb_hit_i(tlb_hit_i), .tlb_pfn_i(tlb_pfn_i),
      .tlb_rd_en_i(tlb_rd_en_i), .tlb_wr_en_i(tlb_wr_en_i), .tlb_for_i(tlb_for_i),
      .tlb_fow_i(tlb_fow_i), .va_rd_i(va_rd_i), .rsp_valid_o(rsp_valid_o),
      .rsp_kind_o(rsp_kind_o), .rsp_paddr_o(rsp_paddr_o), .fault_va_o(fault_va_o),
      .fault_stat_o(fault_stat_o), .fault_form_o(fault_form_o), .fault_lock_o(fault_lock_o),
      .cnt_rd_hit_o(c_rh), .cnt_rd_miss_o(c_rm), .cnt_rd_viol_o(c_rv),
      .cnt_wr_hit_o(c_wh), .cnt_wr_miss_o(c_wm), .cnt_wr_viol_o(c_wv)
   );

   int n_checks = 0, n_fails = 0;
   exp_t sb_q[$];
   bit m_lock = 0;
   logic [VA_W-1:0] m_va = '0, m_fm = '0;
   logic [16:0] m_st = '0;
   int m_cnt[6] = '{0, 0, 0, 0, 0, 0};

   task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic req_t base_req();
      req_t r;
      r.va = 48'h0000_1234_5ABC; r.st = 0; r.pt = 0; r.pal = 0; r.alt = 0;
      r.cm = 2'd0; r.am = 2'd0; r.sp = 0; r.hit = 1; r.pfn = 27'h0ABC_DEF;
      r.re = 4'hF; r.we = 4'hF; r.fr = 0; r.fw = 0; r.opc = 6'h2C; r.rg = 5'd7; r.vrd = 0;
      return r;
   endfunction

   // Expected result from the requirement text (R2..R7)
   task automatic model(input req_t r, output logic [2:0] kind, output logic [5:0] fl,
                        output logic [PA_W-1:0] pa);
      logic [1:0] m;
      logic [5:0] up;
      m  = r.pal ? (r.alt ? r.am : 2'd0) : r.cm;
      up = r.va[47:42];
      kind = 0; fl = 0; pa = 0;
      if (!(up == 6'd0 || up == 6'h3F)) begin
         kind = 2; fl = {1'b1, 3'b000, 1'b1, r.st};
      end else if (r.sp && r.va[42:41] == 2'b10) begin
         if (m != 0) begin kind = 1; fl = {4'b0000, 1'b1, r.st}; end
         else pa = r.va[PA_W-1:0];
      end else if (!r.hit) begin
         kind = r.pt ? 3 : 4; fl = {2'b01, 3'b000, r.st};
      end else if (r.st) begin
         if (!r.we[m]) begin kind = 2; fl = {2'b00, r.fw, 1'b0, 2'b11}; end
         else if (r.fw) begin kind = 2; fl = 6'b001001; end
         else pa = {r.pfn, r.va[PAGE_W-1:0]};
      end else begin
         if (!r.re[m]) begin kind = 1; fl = {3'b000, r.fr, 2'b10}; end
         else if (r.fr) begin kind = 2; fl = 6'b000100; end
         else pa = {r.pfn, r.va[PAGE_W-1:0]};
      end
   endtask

   task automatic issue(input req_t r, input string tag);
      exp_t e;
      logic [5:0] fl;
      bit cap;
      int idx;
      @(negedge clk);
      req_valid_i = 1; req_va_i = r.va; req_store_i = r.st; req_pt_i = r.pt;
      pal_mode_i = r.pal; alt_req_i = r.alt; cur_mode_i = r.cm; alt_mode_i = r.am;
      spage_en_i = r.sp; tlb_hit_i = r.hit; tlb_pfn_i = r.pfn; tlb_rd_en_i = r.re;
      tlb_wr_en_i = r.we; tlb_for_i = r.fr; tlb_fow_i = r.fw; req_opcode_i = r.opc;
      req_reg_i = r.rg; va_rd_i = r.vrd;
      model(r, e.kind, fl, e.pa);
      cap = (e.kind != 0) && !m_lock;
      if (cap) begin
         m_va = r.va; m_st = {r.opc, r.rg, fl};
         m_fm = pt_base_i | (VA_W'(r.va[42:13]) << 3);
         m_lock = 1;
      end else if (r.vrd) m_lock = 0;
      idx = (r.st ? 3 : 0) + ((e.kind == 0) ? 0 : (e.kind >= 3) ? 1 : 2);
      m_cnt[idx]++;
      e.fva = m_va; e.fst = m_st; e.ffm = m_fm; e.lk = m_lock; e.tag = tag;
      sb_q.push_back(e);
      @(posedge clk);
   endtask

   task automatic idle(input bit vrd);
      @(negedge clk);
      req_valid_i = 0; va_rd_i = vrd;
      if (vrd) m_lock = 0;
      @(posedge clk);
      #1;
      chk(rsp_valid_o == 0, "R1 idle no response", 64'(rsp_valid_o), 0);
      chk(fault_lock_o == m_lock, "R10 lock after idle", 64'(fault_lock_o), 64'(m_lock));
   endtask

   // Monitor: pops expectations as responses appear
   always @(negedge clk) begin
      if (rst_n && rsp_valid_o) begin
         exp_t e;
         if (sb_q.size() == 0) chk(0, "R1 unexpected response", 1, 0);
         else begin
            e = sb_q.pop_front();
            chk(rsp_kind_o == e.kind, {e.tag, " kind"}, 64'(rsp_kind_o), 64'(e.kind));
            chk(rsp_paddr_o == e.pa, {e.tag, " paddr"}, 64'(rsp_paddr_o), 64'(e.pa));
            chk(fault_va_o == e.fva, {e.tag, " R9 va word"}, 64'(fault_va_o), 64'(e.fva));
            chk(fault_stat_o == e.fst, {e.tag, " R8 status"}, 64'(fault_stat_o), 64'(e.fst));
            chk(fault_form_o == e.ffm, {e.tag, " R9 form"}, 64'(fault_form_o), 64'(e.ffm));
            chk(fault_lock_o == e.lk, {e.tag, " R10 lock"}, 64'(fault_lock_o), 64'(e.lk));
         end
      end
   end

   bit done = 0;
   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         chk(0, "watchdog expired", 1, 0);
         finish_run();
      end
   end

   initial begin
      req_t r;
      repeat (3) @(posedge clk);
      #1;
      chk(rsp_valid_o == 0, "R1 reset response", 64'(rsp_valid_o), 0);
      chk(fault_lock_o == 0, "R10 reset lock", 64'(fault_lock_o), 0);
      chk(c_rh == 0 && c_wv == 0, "R11 reset counters", 64'(c_rh), 0);
      @(negedge clk); rst_n = 1;

      r = base_req(); r.cm = 2'd3; issue(r, "R7 load hit user");
      r = base_req(); r.st = 1; r.cm = 2'd2; issue(r, "R6 store hit");
      r = base_req(); r.va = 48'h2000_0000_1000; r.st = 1; issue(r, "R3 invalid VA store");
      r = base_req(); r.hit = 0; r.opc = 6'h11; issue(r, "R5 miss while locked R10");
      idle(1);
      r = base_req(); r.st = 1; r.hit = 0; r.pt = 1; r.rg = 5'd31; issue(r, "R5 pt store miss");
      r = base_req(); r.va = 48'h8000_0000_0000; r.vrd = 1; issue(r, "R10 fault with strobe not captured");
      r = base_req(); r.va = 48'hFC00_0012_3456; r.sp = 1; r.cm = 2'd3; r.vrd = 1;
      issue(r, "R4 superpage user with strobe unlocked R10");
      idle(1);
      r = base_req(); r.va = 48'hFC00_0012_3456; r.sp = 1; r.st = 1; issue(r, "R4 superpage kernel store");
      r = base_req(); r.va = 48'hFC00_0012_3456; r.sp = 0; issue(r, "R4 superpage disabled uses lookup");
      r = base_req(); r.pal = 1; r.alt = 1; r.am = 2'd3; r.re = 4'b0001; r.fr = 1;
      issue(r, "R2 alt mode in privileged code R7");
      idle(1);
      r = base_req(); r.pal = 1; r.cm = 2'd3; r.re = 4'b0001; issue(r, "R2 privileged code kernel");
      r = base_req(); r.cm = 2'd1; r.st = 1; r.we = 4'b1101; r.fw = 1; r.opc = 6'h3F;
      issue(r, "R6 store no write enable");
      idle(1);
      r = base_req(); r.st = 1; r.fw = 1; r.rg = 5'd1; issue(r, "R6 store fault-on-write");
      idle(1);
      r = base_req(); r.cm = 2'd2; r.re = 4'b1011; r.fr = 0; issue(r, "R7 load no read enable");
      idle(1);
      r = base_req(); r.fr = 1; issue(r, "R7 load fault-on-read");
      idle(0);
      idle(1);
      idle(0);
      chk(c_rh == m_cnt[0], "R11 load hits", 64'(c_rh), 64'(m_cnt[0]));
      chk(c_rm == m_cnt[1], "R11 load misses", 64'(c_rm), 64'(m_cnt[1]));
      chk(c_rv == m_cnt[2], "R11 load violations", 64'(c_rv), 64'(m_cnt[2]));
      chk(c_wh == m_cnt[3], "R11 store hits", 64'(c_wh), 64'(m_cnt[3]));
      chk(c_wm == m_cnt[4], "R11 store misses", 64'(c_wm), 64'(m_cnt[4]));
      chk(c_wv == m_cnt[5], "R11 store violations", 64'(c_wv), 64'(m_cnt[5]));
      chk(sb_q.size() == 0, "R1 all responses seen", 64'(sb_q.size()), 0);
      done = 1;
      finish_run();
   end
endmodule